// File: doc/BRIEF.md
# Halfword add/subtract execution unit

This unit decodes and executes one family of 32-bit instruction words. Each word adds or subtracts two signed 16-bit halfwords taken from two source registers. The result goes to a destination register in a 32-entry by 32-bit register file that lives inside the unit. A word may saturate its result, and a saturating word that clamps sets a sticky overflow flag. A word may also place its 16-bit result in the upper half of the destination, with zeros below. Any word outside the family raises a one-cycle illegal pulse and changes nothing.

Words arrive one per cycle on a valid-qualified issue port. Source registers are read in the issue cycle. Non-saturating words write back one clock edge after issue. Saturating words write back two edges after issue. When two results complete on the same edge, they are retired in issue order.

A load port fills the register file with operands, and a read port lets the surrounding logic observe any register.

Top module: `hwau_top`

## Requirements
- R1: A word belongs to the family when bits 31-28 are 1101 and bits 27-23 are 01010. In such a word, bits 4-0 name the destination, bits 12-8 the first source (T), and bits 20-16 the second source (S).
- R2: When a valid word is not in the family, `illegal_pulse` is high for exactly the cycle after the issue edge. No register and not the overflow flag change.
- R3: Bit 21 set makes the result the T halfword minus the S halfword. Bit 21 clear makes it their sum.
- R4: With bit 22 clear, the low half of T is used. Bit 6 selects the S half (1 high, 0 low), bit 5 is ignored, and the 16-bit result is sign-extended to 32 bits.
- R5: With bit 22 set, bit 6 selects the T half and bit 5 selects the S half (1 high, 0 low). The result fills bits 31-16 and bits 15-0 are zero.
- R6: With bit 7 clear, the low 16 bits of the exact result are kept and any overflow wraps silently.
- R7: With bit 7 set, the exact 17-bit result is clamped to the range -32768..32767 before extension or shifting. `ovf_flag` is set only when clamping happens.
- R8: `ovf_flag` stays set until `ovf_clear` is sampled high. A new clamp on the same edge as a clear leaves the flag set.
- R9: For an issue edge k, a non-saturating result is readable after edge k+1 and a saturating result after edge k+2. The overflow update lands with the saturating write. Source operands are the register values before edge k.
- R10: When an older saturating result and a younger non-saturating result retire on the same edge to the same register, the younger value remains.
- R11: After reset, every register reads zero and both `ovf_flag` and `illegal_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction word present this cycle |
| issue_word | input | 32 | Instruction word |
| ld_en | input | 1 | Load a register (lowest write priority) |
| ld_addr | input | 5 | Register to load |
| ld_data | input | 32 | Load value |
| ovf_clear | input | 1 | Clear the sticky overflow flag |
| rd_addr | input | 5 | Observation read address |
| rd_data | output | 32 | Register contents at `rd_addr` |
| ovf_flag | output | 1 | Sticky saturation overflow |
| illegal_pulse | output | 1 | One-cycle pulse for a word outside the family |

## Verification
The overflow properties assume that `issue_valid` is low while reset is held. They also assume that only the saturating word issued two edges earlier can set the flag, so any other clear edge must leave it low. The bench drives no issue during reset. Its random phase mixes family words, arbitrary words, loads and clears, and a behavioural model tracks every one, so each stimulus stays within these conditions. Load addresses may coincide with write-backs; the model applies the same lowest priority to loads.

// File: rtl/hwau_pkg.sv
package hwau_pkg;
  localparam logic [3:0] FAM_CLASS = 4'b1101;
  localparam logic [4:0] FAM_MAJOR = 5'b01010;

  typedef struct packed {
    logic       sub;
    logic       shift;
    logic       sat;
    logic       t_hi;
    logic       s_hi;
    logic [4:0] dst;
    logic [4:0] src_t;
    logic [4:0] src_s;
  } dec_t;

  typedef struct packed {
    logic        vld;
    logic        sat;
    logic        clip;
    logic [4:0]  dst;
    logic [31:0] val;
  } stage_t;
endpackage

// File: rtl/hwau_decode.sv
module hwau_decode
  import hwau_pkg::*;
(
  input  logic [31:0] word,
  output logic        in_family,
  output dec_t        dec
);
  logic unused_bits;

  assign unused_bits = ^word[15:13];
  assign in_family   = (word[31:28] == FAM_CLASS) && (word[27:23] == FAM_MAJOR);

  always_comb begin
    dec.sub   = word[21];
    dec.shift = word[22];
    dec.sat   = word[7];
    dec.dst   = word[4:0];
    dec.src_t = word[12:8];
    dec.src_s = word[20:16];
    if (word[22]) begin
      dec.t_hi = word[6];
      dec.s_hi = word[5];
    end else begin
      dec.t_hi = 1'b0;
      dec.s_hi = word[6];
    end
  end
endmodule

// File: rtl/hwau_exec.sv
module hwau_exec #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] opnd_t,
  input  logic [2*HALF_W-1:0] opnd_s,
  input  logic                sub,
  input  logic                shift,
  input  logic                sat,
  input  logic                t_hi,
  input  logic                s_hi,
  output logic [2*HALF_W-1:0] result,
  output logic                clip
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] half_t, half_s, res_h;
  logic [HALF_W:0]   ext_t, ext_s, exact;
  logic              out_of_range;

  assign half_t = t_hi ? opnd_t[WORD_W-1:HALF_W] : opnd_t[HALF_W-1:0];
  assign half_s = s_hi ? opnd_s[WORD_W-1:HALF_W] : opnd_s[HALF_W-1:0];
  assign ext_t  = {half_t[HALF_W-1], half_t};
  assign ext_s  = {half_s[HALF_W-1], half_s};
  assign exact  = sub ? (ext_t - ext_s) : (ext_t + ext_s);

  assign out_of_range = exact[HALF_W] ^ exact[HALF_W-1];
  assign clip         = sat & out_of_range;

  always_comb begin
    if (clip) begin
      res_h = exact[HALF_W] ? {1'b1, {(HALF_W-1){1'b0}}}
                            : {1'b0, {(HALF_W-1){1'b1}}};
    end else begin
      res_h = exact[HALF_W-1:0];
    end
    if (shift) result = {res_h, {HALF_W{1'b0}}};
    else       result = {{HALF_W{res_h[HALF_W-1]}}, res_h};
  end
endmodule

// File: rtl/hwau_regfile.sv
module hwau_regfile #(
  parameter int REG_N  = 32,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_wa,
  input  logic [DATA_W-1:0] ld_wd,
  input  logic              old_we,
  input  logic [AW-1:0]     old_wa,
  input  logic [DATA_W-1:0] old_wd,
  input  logic              yng_we,
  input  logic [AW-1:0]     yng_wa,
  input  logic [DATA_W-1:0] yng_wd,
  input  logic [AW-1:0]     ra_t,
  input  logic [AW-1:0]     ra_s,
  input  logic [AW-1:0]     ra_obs,
  output logic [DATA_W-1:0] rd_t,
  output logic [DATA_W-1:0] rd_s,
  output logic [DATA_W-1:0] rd_obs
);
  logic [DATA_W-1:0] mem [REG_N];

  // Priority on one entry: younger write-back, then older, then load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_N; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < REG_N; i++) begin
        if (yng_we && (yng_wa == AW'(i)))      mem[i] <= yng_wd;
        else if (old_we && (old_wa == AW'(i))) mem[i] <= old_wd;
        else if (ld_we && (ld_wa == AW'(i)))   mem[i] <= ld_wd;
      end
    end
  end

  assign rd_t   = mem[ra_t];
  assign rd_s   = mem[ra_s];
  assign rd_obs = mem[ra_obs];
endmodule

// File: rtl/hwau_top.sv
module hwau_top
  import hwau_pkg::*;
#(
  parameter int REG_N  = 32,
  parameter int HALF_W = 16,
  localparam int AW     = $clog2(REG_N),
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [31:0]       issue_word,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ovf_clear,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf_flag,
  output logic              illegal_pulse
);
  dec_t              dec;
  logic              in_family;
  logic [DATA_W-1:0] opnd_t, opnd_s, result;
  logic              clip;

  stage_t s1_q, s1_d, s2_q, s2_d;
  logic   s1_en, s2_en;
  logic   ovf_q, ovf_d, ill_q, ill_d;

  logic              old_we, yng_we;
  logic [AW-1:0]     old_wa, yng_wa;
  logic [DATA_W-1:0] old_wd, yng_wd;

  hwau_decode u_dec (
    .word      (issue_word),
    .in_family (in_family),
    .dec       (dec)
  );

  hwau_regfile #(.REG_N(REG_N), .DATA_W(DATA_W)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_we  (ld_en),
    .ld_wa  (ld_addr),
    .ld_wd  (ld_data),
    .old_we (old_we),
    .old_wa (old_wa),
    .old_wd (old_wd),
    .yng_we (yng_we),
    .yng_wa (yng_wa),
    .yng_wd (yng_wd),
    .ra_t   (dec.src_t[AW-1:0]),
    .ra_s   (dec.src_s[AW-1:0]),
    .ra_obs (rd_addr),
    .rd_t   (opnd_t),
    .rd_s   (opnd_s),
    .rd_obs (rd_data)
  );

  hwau_exec #(.HALF_W(HALF_W)) u_exe (
    .opnd_t (opnd_t),
    .opnd_s (opnd_s),
    .sub    (dec.sub),
    .shift  (dec.shift),
    .sat    (dec.sat),
    .t_hi   (dec.t_hi),
    .s_hi   (dec.s_hi),
    .result (result),
    .clip   (clip)
  );

  // Write-back selection: stage 2 is the older saturating result.
  always_comb begin
    old_we = s2_q.vld;
    old_wa = s2_q.dst[AW-1:0];
    old_wd = s2_q.val;
    yng_we = s1_q.vld & ~s1_q.sat;
    yng_wa = s1_q.dst[AW-1:0];
    yng_wd = s1_q.val;
  end

  // Next-state logic.
  always_comb begin
    s1_en      = issue_valid;
    s1_d.vld   = issue_valid & in_family;
    s1_d.sat   = dec.sat;
    s1_d.clip  = clip;
    s1_d.dst   = dec.dst;
    s1_d.val   = result;

    s2_en      = s1_q.vld & s1_q.sat;
    s2_d       = s1_q;
    s2_d.vld   = s1_q.vld & s1_q.sat;

    ovf_d      = (ovf_q & ~ovf_clear) | (s2_q.vld & s2_q.clip);
    ill_d      = issue_valid & ~in_family;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q.vld <= 1'b0;
      s2_q.vld <= 1'b0;
      ovf_q    <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      s1_q.vld <= s1_d.vld;
      s2_q.vld <= s2_d.vld;
      ovf_q    <= ovf_d;
      ill_q    <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q.sat  <= 1'b0;
      s1_q.clip <= 1'b0;
      s1_q.dst  <= '0;
      s1_q.val  <= '0;
    end else if (s1_en) begin
      s1_q.sat  <= s1_d.sat;
      s1_q.clip <= s1_d.clip;
      s1_q.dst  <= s1_d.dst;
      s1_q.val  <= s1_d.val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_q.sat  <= 1'b0;
      s2_q.clip <= 1'b0;
      s2_q.dst  <= '0;
      s2_q.val  <= '0;
    end else if (s2_en) begin
      s2_q.sat  <= s2_d.sat;
      s2_q.clip <= s2_d.clip;
      s2_q.dst  <= s2_d.dst;
      s2_q.val  <= s2_d.val;
    end
  end

  assign ovf_flag      = ovf_q;
  assign illegal_pulse = ill_q;
endmodule

// File: rtl/hwau_checker.sv
module hwau_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_valid,
  input logic [31:0] issue_word,
  input logic        ovf_clear,
  input logic        ovf_flag,
  input logic        illegal_pulse
);
  // R2
  illegal_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> $past(issue_valid));

  // R2
  family_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_word[31:23] == 9'b1101_01010) |=> !illegal_pulse);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag);

  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clear && !$past(issue_valid, 2)) |=> !ovf_flag);

  // R7
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(issue_valid, 3) && $past(issue_word[7], 3)));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!ovf_flag && !illegal_pulse));
endmodule

bind hwau_top hwau_checker u_chk (.*);

// File: tb/hwau_top_bench.sv
module hwau_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] issue_word = '0;
  logic        ld_en = 1'b0;
  logic [4:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        ovf_clear = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ovf_flag, illegal_pulse;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hwau_top u_hwau_top (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_word(issue_word),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .ovf_clear(ovf_clear),
    .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag),
    .illegal_pulse(illegal_pulse)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_rf [32];
  bit          m_ovf, m_ill;
  bit          p1_v, p1_sat, p1_clip, p2_v, p2_clip;
  logic [4:0]  p1_d, p2_d;
  logic [31:0] p1_val, p2_val;

  function automatic void model_exec(input logic [31:0] w, input logic [31:0] t,
                                     input logic [31:0] s, output logic [31:0] val,
                                     output bit clipped);
    int a, b, r;
    logic [15:0] h;
    bit th, sh;
    th = w[22] ? w[6] : 1'b0;
    sh = w[22] ? w[5] : w[6];
    a = th ? int'($signed(t[31:16])) : int'($signed(t[15:0]));
    b = sh ? int'($signed(s[31:16])) : int'($signed(s[15:0]));
    r = w[21] ? a - b : a + b;
    clipped = 1'b0;
    if (w[7] && r > 32767)  begin r = 32767;  clipped = 1'b1; end
    if (w[7] && r < -32768) begin r = -32768; clipped = 1'b1; end
    h = r[15:0];
    val = w[22] ? {h, 16'h0000} : {{16{h[15]}}, h};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_rf[i] = '0;
      m_ovf = 0; m_ill = 0; p1_v = 0; p2_v = 0;
      p1_sat = 0; p1_clip = 0; p2_clip = 0;
      p1_d = '0; p2_d = '0; p1_val = '0; p2_val = '0;
    end else begin
      bit fam, n_v, n_clip;
      logic [31:0] n_val;
      fam = (issue_word[31:28] == 4'hD) && (issue_word[27:23] == 5'b01010);
      n_v = issue_valid && fam;
      model_exec(issue_word, m_rf[issue_word[12:8]], m_rf[issue_word[20:16]], n_val, n_clip);
      m_ill = issue_valid && !fam;
      m_ovf = (m_ovf && !ovf_clear) || (p2_v && p2_clip);
      if (ld_en) m_rf[ld_addr] = ld_data;
      if (p2_v) m_rf[p2_d] = p2_val;
      if (p1_v && !p1_sat) m_rf[p1_d] = p1_val;
      p2_v = p1_v && p1_sat; p2_d = p1_d; p2_val = p1_val; p2_clip = p1_clip;
      p1_v = n_v; p1_sat = issue_word[7]; p1_d = issue_word[4:0];
      p1_val = n_val; p1_clip = n_clip;
    end
  end

  // Clock-by-clock comparison against the model.
  always @(negedge clk) begin
    if (cmp_on) begin
      #3;
      chk("R9", "model register", rd_data, m_rf[rd_addr]);
      chk("R8", "model ovf_flag", {31'b0, ovf_flag}, {31'b0, m_ovf});
      chk("R2", "model illegal_pulse", {31'b0, illegal_pulse}, {31'b0, m_ill});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_issue(input logic [31:0] w);
    issue_valid = 1'b1; issue_word = w;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic do_load(input logic [4:0] a, input logic [31:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, $sformatf("r%0d", a), rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    rd_chk("R11", 5'd0, 32'h0);
    rd_chk("R11", 5'd17, 32'h0);
    rd_chk("R11", 5'd31, 32'h0);
    chk("R11", "ovf_flag", {31'b0, ovf_flag}, 32'h0);
    chk("R11", "illegal_pulse", {31'b0, illegal_pulse}, 32'h0);
    cmp_on = 1'b1;

    do_load(5'd21, 32'h1234_7FFF);
    do_load(5'd31, 32'h0001_0002);

    // R1 / R6 / R9: add low halves, wraps; visible one edge later
    do_issue(32'hd51fd511);
    rd_chk("R9", 5'd17, 32'h0);
    @(negedge clk);
    rd_chk("R6", 5'd17, 32'hFFFF_8001);
    rd_chk("R1", 5'd21, 32'h1234_7FFF);

    // R4: unshifted, bit 6 selects the high half of S
    do_issue(32'hd51fd551);
    @(negedge clk);
    rd_chk("R4", 5'd17, 32'hFFFF_8000);

    // R7 / R9: saturating add clamps high, two-edge latency
    do_issue(32'hd51fd591);
    @(negedge clk);
    rd_chk("R9", 5'd17, 32'hFFFF_8000);
    chk("R9", "ovf before write-back", {31'b0, ovf_flag}, 32'h0);
    @(negedge clk);
    rd_chk("R7", 5'd17, 32'h0000_7FFF);
    chk("R7", "ovf after clamp", {31'b0, ovf_flag}, 32'h1);

    // R8: sticky, then cleared
    repeat (3) @(negedge clk);
    chk("R8", "ovf held", {31'b0, ovf_flag}, 32'h1);
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
    chk("R8", "ovf cleared", {31'b0, ovf_flag}, 32'h0);

    // R5 / R3: shifted saturating subtract of high halves, no clamp
    do_issue(32'hd57fd5f1);
    @(negedge clk);
    @(negedge clk);
    rd_chk("R5", 5'd17, 32'h1233_0000);
    chk("R7", "no clamp no ovf", {31'b0, ovf_flag}, 32'h0);

    // R3: unshifted subtract of low halves
    do_issue(32'hd53fd511);
    @(negedge clk);
    rd_chk("R3", 5'd17, 32'h0000_7FFD);

    // R7: saturating subtract clamps low
    do_load(5'd21, 32'h1234_8000);
    do_issue(32'hd53fd591);
    @(negedge clk);
    @(negedge clk);
    rd_chk("R7", 5'd17, 32'hFFFF_8000);
    chk("R7", "ovf after low clamp", {31'b0, ovf_flag}, 32'h1);
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;

    // R10: older saturating and younger plain write-back on the same edge
    do_issue(32'hd51fd591);
    do_issue(32'hd53fd511);
    @(negedge clk);
    rd_chk("R10", 5'd17, 32'h0000_7FFE);
    @(negedge clk);
    rd_chk("R10", 5'd17, 32'h0000_7FFE);

    // R2: wrong major field, then a wrong class
    do_issue(32'hd59fd511);
    chk("R2", "pulse on bad major", {31'b0, illegal_pulse}, 32'h1);
    @(negedge clk);
    chk("R2", "pulse one cycle", {31'b0, illegal_pulse}, 32'h0);
    rd_chk("R2", 5'd17, 32'h0000_7FFE);
    do_issue(32'h051fd591);
    chk("R2", "pulse on bad class", {31'b0, illegal_pulse}, 32'h1);
    @(negedge clk);
    @(negedge clk);
    rd_chk("R2", 5'd17, 32'h0000_7FFE);
    chk("R2", "ovf untouched", {31'b0, ovf_flag}, 32'h0);

    // Random phase, checked against the model every cycle.
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] w;
      w = $urandom;
      if (($urandom % 5) != 0) begin
        w[31:23] = 9'b1101_01010;
        w[20:16] = 5'($urandom % 6);
        w[12:8]  = 5'($urandom % 6);
        w[4:0]   = 5'($urandom % 6);
      end
      issue_valid = ($urandom % 4) != 0;
      issue_word  = w;
      ld_en       = ($urandom % 8) == 0;
      ld_addr     = 5'($urandom % 6);
      ld_data     = $urandom;
      ovf_clear   = ($urandom % 12) == 0;
      rd_addr     = 5'($urandom % 6);
      @(negedge clk);
    end
    issue_valid = 1'b0; ld_en = 1'b0; ovf_clear = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule